// File: doc/BRIEF.md
# HDLC Receive Frame Status Generator

This block follows the flag-hunting and zero-deletion stages of an HDLC receiver. It takes the destuffed byte stream, a start-of-frame marker and an end-of-frame marker, and judges each finished frame. It then passes the frame bytes to a receive FIFO and adds one packed status byte after them. The status byte records whether the frame was valid, whether bytes were lost, the CRC verdict, an abort, and four address-information flags that an upstream comparator supplies.

The smallest frame worth reporting depends on four static settings together: the operating mode, the address width, the CRC polynomial, and whether the receive CRC is kept. A frame that ends below that length is dropped without a trace. To allow this, bytes are held in a small circular buffer. They only become visible on the FIFO port once the frame has reached its minimum length. When a frame is dropped, the buffer's write pointer is wound back.

Top module: `hdlc_rx_status`

## Requirements
- R1: After reset the FIFO port shows no valid byte (`fifo_vld` = 0) until a frame is reported.
- R2: A reported frame appears on the FIFO port as its data bytes in arrival order, followed by one status byte. The status byte holds: bit 7 valid frame, bit 6 data overflow, bit 5 CRC good, bit 4 abort, bits 3:0 the `in_addr_flags` value sampled at frame end, copied bit for bit. A whole-byte frame that ends with `in_eof` and has no abort has bit 7 = 1.
- R3: In mode 0 (auto) and mode 1 (non-auto) the minimum frame length in whole bytes is as follows. With `cfg_rcrc` = 0: 16-bit address gives 4 (CRC-CCITT) or 6 (CRC-32); 8-bit address gives 3 or 5. With `cfg_rcrc` = 1: 3 for a 16-bit address and 2 for an 8-bit address, for either CRC.
- R4: In mode 2 the minimum is 3 (CRC-CCITT) or 5 (CRC-32). In mode 3 it is 2 or 4. Address width and `cfg_rcrc` have no effect in these modes.
- R5: A frame with fewer whole bytes than the minimum writes nothing to the FIFO port: no data bytes and no status byte.
- R6: A frame with a nonzero `in_resid` at end of frame (not a whole number of bytes) has status bit 7 = 0 and bit 5 = 0. Its length is judged on whole bytes only.
- R7: `in_abort` ends the frame at once. If the frame reached its minimum length, the status byte has bit 4 = 1 and bits 7 and 5 = 0. Otherwise the frame is dropped.
- R8: For a whole-byte frame without abort, status bit 5 equals `in_crc_ok` sampled in the end-of-frame cycle.
- R9: The byte count clears on every start-of-frame and at every frame end. A short frame that follows a long one is therefore judged on its own length.
- R10: A data byte that arrives while the buffer has no free slot is discarded, and so is every later byte of that frame. That frame's status has bit 6 = 1. If the status byte cannot be stored at frame end, it waits until a slot frees.
- R11: A byte moves to the FIFO in every cycle where `fifo_vld` and `fifo_rdy` are both 1. While `fifo_vld` = 1 and `fifo_rdy` = 0, `fifo_vld` and `fifo_data` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 2 | 0 auto, 1 non-auto, 2 transparent-1, 3 transparent-0 |
| cfg_addr16 | input | 1 | 1 = 16-bit address, 0 = 8-bit |
| cfg_crc32 | input | 1 | 1 = CRC-32, 0 = CRC-CCITT |
| cfg_rcrc | input | 1 | Receive-CRC handling selection |
| in_sof | input | 1 | Start-of-frame pulse |
| in_byte_vld | input | 1 | Data byte strobe |
| in_byte | input | 8 | Data byte |
| in_eof | input | 1 | End-of-frame pulse |
| in_resid | input | 3 | Bits left over in the last partial byte, sampled with `in_eof` |
| in_abort | input | 1 | Abort indication |
| in_crc_ok | input | 1 | CRC-good flag from the external checker |
| in_addr_flags | input | 4 | Address information for status bits 3:0 |
| fifo_vld | output | 1 | A committed byte is offered |
| fifo_data | output | 8 | Offered byte |
| fifo_rdy | input | 1 | FIFO accepts a byte |

## Verification
The bench builds the block with an 8-entry buffer and a 12-bit byte counter. With a buffer this small, one 12-byte frame held behind a deasserted `fifo_rdy` fills the buffer. That reaches the discard path, the overflow bit and the deferred status write, all within a few dozen cycles. The bench also runs every combination of mode, address width, CRC type and receive-CRC handling (32 settings). Each setting gets a frame one byte short of the minimum and a frame of exactly the minimum, so every threshold edge is tested.

// File: rtl/hdlc_rxst_pkg.sv
package hdlc_rxst_pkg;

  typedef enum logic [1:0] {
    MODE_AUTO    = 2'd0,
    MODE_NONAUTO = 2'd1,
    MODE_TRANSP1 = 2'd2,
    MODE_TRANSP0 = 2'd3
  } rx_mode_e;

  typedef struct packed {
    logic       vfr;
    logic       ovf;
    logic       crc;
    logic       abrt;
    logic [3:0] addr;
  } rx_stat_t;

  // Minimum reportable length in whole bytes.
  function automatic logic [2:0] min_frame_len(input logic [1:0] mode,
                                               input logic addr16,
                                               input logic crc32,
                                               input logic rcrc);
    logic [2:0] n;
    case (mode)
      MODE_TRANSP1: n = crc32 ? 3'd5 : 3'd3;
      MODE_TRANSP0: n = crc32 ? 3'd4 : 3'd2;
      default: begin
        if (rcrc)        n = addr16 ? 3'd3 : 3'd2;
        else if (addr16) n = crc32 ? 3'd6 : 3'd4;
        else             n = crc32 ? 3'd5 : 3'd3;
      end
    endcase
    return n;
  endfunction

  function automatic rx_stat_t pack_status(input logic aborted,
                                           input logic lost,
                                           input logic crc_ok,
                                           input logic [2:0] resid,
                                           input logic [3:0] addr);
    rx_stat_t s;
    logic whole;
    whole  = (resid == 3'd0);
    s.vfr  = whole & ~aborted;
    s.ovf  = lost;
    s.crc  = crc_ok & whole & ~aborted;
    s.abrt = aborted;
    s.addr = addr;
    return s;
  endfunction

endpackage

// File: rtl/rxst_frame_ctl.sv
module rxst_frame_ctl
  import hdlc_rxst_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_addr16,
  input  logic             cfg_crc32,
  input  logic             cfg_rcrc,
  input  logic             in_sof,
  input  logic             in_byte_vld,
  input  logic             in_eof,
  input  logic             in_abort,
  input  logic             in_crc_ok,
  input  logic [2:0]       in_resid,
  input  logic [3:0]       in_addr_flags,
  input  logic             room,
  output logic             data_wr,
  output logic             commit_data,
  output logic             rollback,
  output logic             end_rep,
  output logic             end_drop,
  output logic [7:0]       stat_new,
  output logic [CNT_W-1:0] byte_cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             frame_q;
  logic             ovf_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] min_len;
  logic [CNT_W-1:0] cnt_inc;
  logic             byte_evt;
  logic             end_evt;
  logic             ovf_evt;
  logic             enough_now;
  logic             enough_next;
  rx_stat_t         st;

  always_comb begin
    min_len     = CNT_W'(min_frame_len(cfg_mode, cfg_addr16, cfg_crc32, cfg_rcrc));
    cnt_inc     = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_W'(1);
    byte_evt    = frame_q & in_byte_vld & ~in_sof & ~in_eof & ~in_abort;
    end_evt     = frame_q & (in_eof | in_abort) & ~in_sof;
    enough_now  = (cnt_q >= min_len);
    enough_next = (cnt_inc >= min_len);
    data_wr     = byte_evt & ~ovf_q & room;
    ovf_evt     = byte_evt & ~ovf_q & ~room;
    commit_data = byte_evt & enough_next;
    end_rep     = end_evt & enough_now;
    end_drop    = end_evt & ~enough_now;
    rollback    = end_drop | in_sof;
    st          = pack_status(in_abort, ovf_q, in_crc_ok, in_resid, in_addr_flags);
    stat_new    = st;
  end

  assign byte_cnt = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= 1'b0;
      ovf_q   <= 1'b0;
      cnt_q   <= '0;
    end else if (in_sof) begin
      frame_q <= 1'b1;
      ovf_q   <= 1'b0;
      cnt_q   <= '0;
    end else if (end_evt) begin
      frame_q <= 1'b0;
      ovf_q   <= 1'b0;
      cnt_q   <= '0;
    end else if (byte_evt) begin
      cnt_q <= cnt_inc;
      if (ovf_evt) ovf_q <= 1'b1;
    end
  end

endmodule

// File: rtl/rxst_commit_buf.sv
module rxst_commit_buf #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit,
  input  logic              rollback,
  input  logic              rd_rdy,
  output logic              rd_vld,
  output logic [DATA_W-1:0] rd_data,
  output logic [PW-1:0]     free,
  output logic [PW-1:0]     occ,
  output logic [PW-1:0]     cmt_ptr
);

  logic [PW-1:0]     wr_q;
  logic [PW-1:0]     cmt_q;
  logic [PW-1:0]     rd_q;
  logic [DATA_W-1:0] mem [DEPTH];
  logic              pop;

  assign occ     = wr_q - rd_q;
  assign free    = PW'(DEPTH) - occ;
  assign rd_vld  = (rd_q != cmt_q);
  assign rd_data = mem[rd_q[AW-1:0]];
  assign pop     = rd_vld & rd_rdy;
  assign cmt_ptr = cmt_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_q[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      cmt_q <= '0;
      rd_q  <= '0;
    end else begin
      if (pop) rd_q <= rd_q + PW'(1);
      if (wr_en) begin
        wr_q <= wr_q + PW'(1);
        if (commit) cmt_q <= wr_q + PW'(1);
      end else if (commit) begin
        cmt_q <= wr_q;
      end else if (rollback) begin
        wr_q <= cmt_q;
      end
    end
  end

endmodule

// File: rtl/hdlc_rx_status.sv
module hdlc_rx_status
  import hdlc_rxst_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_addr16,
  input  logic       cfg_crc32,
  input  logic       cfg_rcrc,
  input  logic       in_sof,
  input  logic       in_byte_vld,
  input  logic [7:0] in_byte,
  input  logic       in_eof,
  input  logic [2:0] in_resid,
  input  logic       in_abort,
  input  logic       in_crc_ok,
  input  logic [3:0] in_addr_flags,
  output logic       fifo_vld,
  output logic [7:0] fifo_data,
  input  logic       fifo_rdy
);

  localparam int PW = $clog2(DEPTH) + 1;

  logic [PW-1:0]    buf_free;
  logic [PW-1:0]    buf_occ;
  logic [PW-1:0]    cmt_ptr;
  logic [CNT_W-1:0] byte_cnt;
  logic             slot_ok;
  logic             room_ok;
  logic             data_wr;
  logic             commit_data;
  logic             rollback;
  logic             end_rep;
  logic             end_drop;
  logic [7:0]       stat_new;
  logic [7:0]       stat_hold_q;
  logic             stat_pend_q;
  logic             stat_wr_now;
  logic             wr_en;
  logic             commit;
  logic [7:0]       wr_data;

  assign slot_ok     = (buf_free != '0);
  assign room_ok     = slot_ok & ~stat_pend_q;
  assign stat_wr_now = slot_ok & (stat_pend_q | end_rep);
  assign wr_en       = data_wr | stat_wr_now;
  assign commit      = commit_data | stat_wr_now;
  assign wr_data     = stat_pend_q ? stat_hold_q : (end_rep ? stat_new : in_byte);

  rxst_frame_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_mode      (cfg_mode),
    .cfg_addr16    (cfg_addr16),
    .cfg_crc32     (cfg_crc32),
    .cfg_rcrc      (cfg_rcrc),
    .in_sof        (in_sof),
    .in_byte_vld   (in_byte_vld),
    .in_eof        (in_eof),
    .in_abort      (in_abort),
    .in_crc_ok     (in_crc_ok),
    .in_resid      (in_resid),
    .in_addr_flags (in_addr_flags),
    .room          (room_ok),
    .data_wr       (data_wr),
    .commit_data   (commit_data),
    .rollback      (rollback),
    .end_rep       (end_rep),
    .end_drop      (end_drop),
    .stat_new      (stat_new),
    .byte_cnt      (byte_cnt)
  );

  rxst_commit_buf #(.DEPTH(DEPTH), .DATA_W(8)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .commit   (commit),
    .rollback (rollback),
    .rd_rdy   (fifo_rdy),
    .rd_vld   (fifo_vld),
    .rd_data  (fifo_data),
    .free     (buf_free),
    .occ      (buf_occ),
    .cmt_ptr  (cmt_ptr)
  );

  // A status byte that finds no slot waits here; the next frame's data is
  // discarded meanwhile.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_pend_q <= 1'b0;
      stat_hold_q <= '0;
    end else if (stat_pend_q) begin
      if (slot_ok) stat_pend_q <= 1'b0;
    end else if (end_rep && !slot_ok) begin
      stat_pend_q <= 1'b1;
      stat_hold_q <= stat_new;
    end
  end

endmodule

// File: rtl/rxst_chk.sv
module rxst_chk #(
  parameter int DEPTH = 8,
  parameter int PW    = 4,
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_vld,
  input logic             fifo_rdy,
  input logic [7:0]       fifo_data,
  input logic [PW-1:0]    buf_occ,
  input logic [PW-1:0]    cmt_ptr,
  input logic             end_drop,
  input logic             end_rep,
  input logic             stat_wr_now,
  input logic [7:0]       stat_new,
  input logic             in_sof,
  input logic             in_eof,
  input logic             in_abort,
  input logic [2:0]       in_resid,
  input logic [CNT_W-1:0] byte_cnt
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    buf_occ <= PW'(DEPTH)); // R10

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_vld && !fifo_rdy |=> fifo_vld && $stable(fifo_data)); // R11

  AST_SHORT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    end_drop && !stat_wr_now |=> $stable(cmt_ptr)); // R5

  AST_PARTIAL_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    end_rep && in_eof && !in_abort && in_resid != 3'd0 |-> !stat_new[7] && !stat_new[5]); // R6

  AST_ABORT_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    end_rep && in_abort |-> stat_new[4] && !stat_new[7] && !stat_new[5]); // R7

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    in_sof |=> byte_cnt == '0); // R9

endmodule

bind hdlc_rx_status rxst_chk #(.DEPTH(DEPTH), .PW(PW), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fifo_vld    (fifo_vld),
  .fifo_rdy    (fifo_rdy),
  .fifo_data   (fifo_data),
  .buf_occ     (buf_occ),
  .cmt_ptr     (cmt_ptr),
  .end_drop    (end_drop),
  .end_rep     (end_rep),
  .stat_wr_now (stat_wr_now),
  .stat_new    (stat_new),
  .in_sof      (in_sof),
  .in_eof      (in_eof),
  .in_abort    (in_abort),
  .in_resid    (in_resid),
  .byte_cnt    (byte_cnt)
);

// File: tb/sim_hdlc_rx_status.sv
module sim_hdlc_rx_status;
  localparam int DEPTH = 8;
  localparam int CNT_W = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic       cfg_addr16 = 1'b0;
  logic       cfg_crc32 = 1'b0;
  logic       cfg_rcrc = 1'b0;
  logic       in_sof = 1'b0;
  logic       in_byte_vld = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       in_eof = 1'b0;
  logic [2:0] in_resid = 3'd0;
  logic       in_abort = 1'b0;
  logic       in_crc_ok = 1'b0;
  logic [3:0] in_addr_flags = 4'h0;
  logic       fifo_vld;
  logic [7:0] fifo_data;
  logic       fifo_rdy = 1'b1;

  int         checks = 0;
  int         fails = 0;
  logic [7:0] got[$];
  logic [7:0] exp_q[$];
  logic [7:0] seq = 8'h01;

  always #5 clk = ~clk;

  hdlc_rx_status #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_addr16(cfg_addr16),
    .cfg_crc32(cfg_crc32), .cfg_rcrc(cfg_rcrc), .in_sof(in_sof),
    .in_byte_vld(in_byte_vld), .in_byte(in_byte), .in_eof(in_eof),
    .in_resid(in_resid), .in_abort(in_abort), .in_crc_ok(in_crc_ok),
    .in_addr_flags(in_addr_flags), .fifo_vld(fifo_vld), .fifo_data(fifo_data),
    .fifo_rdy(fifo_rdy)
  );

  // Record every transfer (R11): offered at the falling edge, taken at the next rise.
  always @(negedge clk) if (rst_n && fifo_vld && fifo_rdy) got.push_back(fifo_data);

  function automatic int want_min(input logic [1:0] m, input logic a16,
                                  input logic c32, input logic rc);
    int b;
    if (m == 2'd3)      b = 2;
    else if (m == 2'd2) b = 3;
    else                b = a16 ? 4 : 3;
    if (m < 2'd2 && rc) return b - 1;
    return c32 ? b + 2 : b;
  endfunction

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic check1(input string tag, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, expv);
    end
  endtask

  // keep: how many data bytes the buffer can take; beyond it, loss is expected.
  task automatic send(input int n, input logic [2:0] res, input logic ok,
                      input logic [3:0] af, input bit ab, input int keep);
    bit rep;
    rep = (n >= want_min(cfg_mode, cfg_addr16, cfg_crc32, cfg_rcrc));
    tick; in_sof = 1'b1;
    tick; in_sof = 1'b0;
    for (int i = 0; i < n; i++) begin
      in_byte_vld = 1'b1;
      in_byte = seq;
      if (rep && i < keep) exp_q.push_back(seq);
      seq++;
      tick;
    end
    in_byte_vld = 1'b0;
    if (ab) in_abort = 1'b1;
    else begin in_eof = 1'b1; in_resid = res; end
    in_crc_ok = ok;
    in_addr_flags = af;
    tick;
    in_eof = 1'b0; in_abort = 1'b0; in_resid = 3'd0; in_crc_ok = 1'b0;
    if (rep) exp_q.push_back({(res == 3'd0) && !ab, n > keep,
                              ok && (res == 3'd0) && !ab, ab, af});
  endtask

  task automatic drain_check(input string tag);
    fifo_rdy = 1'b1;
    repeat (24) tick;
    checks++;
    if (got.size() != exp_q.size()) begin
      fails++;
      $display("FAIL %s: actual count %0d expected count %0d", tag, got.size(), exp_q.size());
    end else begin
      foreach (exp_q[k]) check1(tag, got[k], exp_q[k]);
    end
    got.delete();
    exp_q.delete();
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic a16, input logic c32, input logic rc);
    cfg_mode = m; cfg_addr16 = a16; cfg_crc32 = c32; cfg_rcrc = rc;
  endtask

  task automatic t_reset;
    repeat (3) tick;
    checks++;
    if (fifo_vld !== 1'b0) begin
      fails++;
      $display("FAIL R1: actual fifo_vld %b expected 0", fifo_vld);
    end
  endtask

  task automatic t_valid_frame;   // R2, R8
    set_cfg(2'd0, 1'b0, 1'b0, 1'b0);
    send(5, 3'd0, 1'b1, 4'hA, 1'b0, 99);
    drain_check("R2 valid frame");
    send(4, 3'd0, 1'b0, 4'h3, 1'b0, 99);
    drain_check("R8 crc bad");
  endtask

  task automatic t_thresholds;    // R3, R4, R5, R9
    for (int m = 0; m < 4; m++)
      for (int cf = 0; cf < 8; cf++) begin
        int mn;
        set_cfg(2'(m), cf[2], cf[1], cf[0]);
        mn = want_min(2'(m), cf[2], cf[1], cf[0]);
        send(mn + 3, 3'd0, 1'b1, 4'h5, 1'b0, 99);
        send(mn - 1, 3'd0, 1'b1, 4'h5, 1'b0, 99);
        send(mn, 3'd0, 1'b1, 4'h6, 1'b0, 99);
        drain_check(m < 2 ? "R3 R5 R9 threshold" : "R4 R5 R9 threshold");
      end
  endtask

  task automatic t_residual;      // R6
    set_cfg(2'd0, 1'b0, 1'b0, 1'b0);
    send(3, 3'd1, 1'b1, 4'h9, 1'b0, 99);
    drain_check("R6 partial byte");
    send(2, 3'd3, 1'b1, 4'h9, 1'b0, 99);
    drain_check("R6 partial short");
  endtask

  task automatic t_abort;         // R7
    set_cfg(2'd0, 1'b0, 1'b0, 1'b0);
    send(4, 3'd0, 1'b1, 4'hC, 1'b1, 99);
    drain_check("R7 abort reported");
    send(1, 3'd0, 1'b1, 4'hC, 1'b1, 99);
    drain_check("R7 abort short");
  endtask

  task automatic t_overflow;      // R10, R11
    logic [7:0] first;
    set_cfg(2'd0, 1'b0, 1'b0, 1'b0);
    fifo_rdy = 1'b0;
    first = seq;
    send(12, 3'd0, 1'b1, 4'h7, 1'b0, DEPTH);
    repeat (3) tick;
    checks++;
    if (fifo_vld !== 1'b1 || fifo_data !== first) begin
      fails++;
      $display("FAIL R11 stall: actual %b/%02h expected 1/%02h", fifo_vld, fifo_data, first);
    end
    drain_check("R10 overflow");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) tick;
    rst_n = 1'b1;
    t_reset();
    t_valid_frame();
    t_thresholds();
    t_residual();
    t_abort();
    t_overflow();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule